// File: doc/BRIEF.md
# Audio Interrupt Status Register

This block gathers interrupt causes from a set of audio sub-units into one 32-bit status word. The sub-units are two serial audio transmitters, a digital audio interface transmitter and receiver, the user and Q subcode channel holding registers, two processor data input paths and a periodic audio tick. Each of them drives one line of `src_i`, and the line's bit position fixes its meaning. An aggregated interrupt line goes to the processor, filtered by a 32-bit enable mask.

Bits come in two kinds. Event bits latch any cycle in which their source line is high. They stay set until software writes a one to the same position of the clear register. Condition bits mirror a holding register: transmit empty, next byte first of block, receive full. Each is set by a rising edge of its source level and is cleared only as a side effect of the matching data access, which arrives as a strobe from the holding register logic. Bits 7 to 0 are reserved.

Software reaches the block through a small register bus with three registers. Address 0 is the status register and is read only. Address 1 is the clear register and is write only. Address 2 is the mask register.

Top module: `audio_irq_ctrl`

## Requirements
- R1: After synchronous reset the status word, the mask and `irq_o` are all zero, and a status read returns 0.
- R2: Event bits are 31..22, 20, 17 and 15..8. An event bit is set on the clock edge at which its `src_i` line is high, and it stays set after the line falls.
- R3: A bus write to address 1 clears every event bit whose position in `bus_wdata` is 1. Positions written as 0 are left unchanged.
- R4: If an event bit's source is high on the same edge as a clear-register write that targets it, the bit stays set.
- R5: Condition bits are 21, 19, 18 and 16. A condition bit is set only by a low-to-high change of its `src_i` line. A level held high after the bit has been cleared does not set it again.
- R6: `utx_wr_stb` clears bits 21 and 19, `urx_rd_stb` clears bit 18 and `qrx_rd_stb` clears bit 16. Writes to the clear register leave all condition bits unchanged.
- R7: Status bits 7..0 always read as 0 and ignore their `src_i` lines.
- R8: The mask register at address 2 can be written and read back. `irq_o` is registered: it goes high one cycle after a status bit whose mask bit is 1 becomes set, and it stays low while no set bit is enabled.
- R9: A read returns data in `bus_rdata` on the cycle after `bus_en` is high with `bus_we` low. Reads of address 1 and address 3 return 0, and writes to address 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Per-bit event pulses and condition levels from the sub-units |
| utx_wr_stb | input | 1 | Processor wrote the user channel transmit register |
| urx_rd_stb | input | 1 | Processor read the user channel receive register |
| qrx_rd_stb | input | 1 | Processor read the Q channel receive register |
| bus_en | input | 1 | Register access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered aggregated interrupt |

## Verification
The main function is exercised with a vector table. The table sets single event bits, then groups of event bits, then condition bits mixed with event bits. In between it writes partial and all-ones clear masks, so that sticky retention, selective clearing and the immunity of condition bits to the clear register each show up as a distinct read-back word. One vector raises a source on the same edge as its clear, which separates set-priority from clear-priority. Another vector drives only reserved lines, which exposes any leakage into bits 7..0. Directed tests hold a condition level high across its strobe, which separates edge setting from level setting. They pulse each access strobe on its own to confirm which bits it owns. They also compare masked against unmasked sources to check the interrupt line and its one-cycle latency.

// File: rtl/airq_pkg.sv
package airq_pkg;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned ADDR_W = 2;

  // bit positions whose behaviour depends on a dedicated data strobe
  localparam int unsigned B_UTX_EMPTY = 21;
  localparam int unsigned B_UTX_FIRST = 19;
  localparam int unsigned B_URX_FULL  = 18;
  localparam int unsigned B_QRX_FULL  = 16;

  localparam logic [STAT_W-1:0] COND_MASK =
    (STAT_W'(1) << B_UTX_EMPTY) | (STAT_W'(1) << B_UTX_FIRST) |
    (STAT_W'(1) << B_URX_FULL)  | (STAT_W'(1) << B_QRX_FULL);
  localparam logic [STAT_W-1:0] RSVD_MASK = STAT_W'(8'hFF);
  localparam logic [STAT_W-1:0] EVT_MASK  = ~(COND_MASK | RSVD_MASK);

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 2'd0,
    A_CLEAR  = 2'd1,
    A_ENABLE = 2'd2,
    A_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/airq_status.sv
module airq_status
  import airq_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  input  logic         utx_wr_stb,
  input  logic         urx_rd_stb,
  input  logic         qrx_rd_stb,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] acc_stb;   // data-access clear strobe per condition bit
  logic [W-1:0] bit_q;

  always_comb begin
    acc_stb = '0;
    acc_stb[B_UTX_EMPTY] = utx_wr_stb;
    acc_stb[B_UTX_FIRST] = utx_wr_stb;
    acc_stb[B_URX_FULL]  = urx_rd_stb;
    acc_stb[B_QRX_FULL]  = qrx_rd_stb;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (EVT_MASK[i]) begin : g_evt
      logic wipe;
      assign wipe = clr_we & clr_data[i];
      always_ff @(posedge clk) begin
        if (rst) bit_q[i] <= 1'b0;
        else     bit_q[i] <= src_i[i] | (bit_q[i] & ~wipe);
      end
    end else if (COND_MASK[i]) begin : g_cond
      logic prev_q;
      logic rise;
      assign rise = src_i[i] & ~prev_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q   <= 1'b0;
          bit_q[i] <= 1'b0;
        end else begin
          prev_q   <= src_i[i];
          bit_q[i] <= rise | (bit_q[i] & ~acc_stb[i]);
        end
      end
    end else begin : g_rsvd
      assign bit_q[i] = 1'b0;
    end
  end

  assign stat_q = bit_q;

  // R2: event bits never drop without a clear-register write
  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_we) |-> ((stat_q & $past(stat_q) & EVT_MASK) == ($past(stat_q) & EVT_MASK)));

  // R3: targeted event bits with no source fall after a clear write
  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((stat_q & $past(clr_data) & ~$past(src_i) & EVT_MASK) == '0));

  // R4: a source high always lands, clear or not
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(src_i) & EVT_MASK) == ($past(src_i) & EVT_MASK)));

  // R5: condition bit set only after a source edge
  assert_edge_only_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[B_URX_FULL]) |-> ($past(src_i[B_URX_FULL]) && !$past(src_i[B_URX_FULL], 2)));

  // R6: read strobe clears the receive-full bit when no new edge
  assert_strobe_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (urx_rd_stb && !src_i[B_URX_FULL]) |=> !stat_q[B_URX_FULL]);

  // R6: clear register cannot touch a condition bit
  assert_cond_immune_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !qrx_rd_stb && stat_q[B_QRX_FULL]) |=> stat_q[B_QRX_FULL]);
endmodule

// File: rtl/airq_regs.sv
module airq_regs
  import airq_pkg::*;
#(
  parameter int unsigned W  = STAT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  stat_q,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  mask_q,
  output logic          clr_we,
  output logic [W-1:0]  clr_data
);
  logic wr, rd;
  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  assign clr_we   = wr && (bus_addr == AW'(A_CLEAR));
  assign clr_data = bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (wr && (bus_addr == AW'(A_ENABLE))) mask_q <= bus_wdata;
  end

  logic [W-1:0] rd_mux;
  always_comb begin
    unique case (bus_addr)
      AW'(A_STATUS): rd_mux = stat_q;
      AW'(A_ENABLE): rd_mux = mask_q;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  // R7: status reads never carry reserved bits
  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == AW'(A_STATUS)) |=> (bus_rdata[7:0] == 8'h00));

  // R9: clear-register address reads back zero
  assert_clr_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == AW'(A_CLEAR)) |=> (bus_rdata == '0));
endmodule

// File: rtl/airq_irq.sv
module airq_irq
  import airq_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_q,
  input  logic [W-1:0] mask_q,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_q & mask_q);
  end

  // R8: with nothing enabled the line stays low
  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_q);
endmodule

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl
  import airq_pkg::*;
#(
  parameter int unsigned W  = STAT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  src_i,
  input  logic          utx_wr_stb,
  input  logic          urx_rd_stb,
  input  logic          qrx_rd_stb,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq_o
);
  logic [W-1:0] stat_q, mask_q, clr_data;
  logic         clr_we;

  airq_status #(.W(W)) u_status (
    .clk(clk), .rst(rst), .src_i(src_i),
    .clr_we(clr_we), .clr_data(clr_data),
    .utx_wr_stb(utx_wr_stb), .urx_rd_stb(urx_rd_stb), .qrx_rd_stb(qrx_rd_stb),
    .stat_q(stat_q)
  );

  airq_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_q(stat_q),
    .bus_rdata(bus_rdata), .mask_q(mask_q),
    .clr_we(clr_we), .clr_data(clr_data)
  );

  airq_irq #(.W(W)) u_irq (
    .clk(clk), .rst(rst), .stat_q(stat_q), .mask_q(mask_q), .irq_q(irq_o)
  );
endmodule

// File: tb/tb_audio_irq_ctrl.sv
module tb_audio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {src[97:66], op[65:64] (0 none,1 clear,2 mask), wdata[63:32], expected status[31:0]}
  localparam logic [97:0] VEC [NV] = '{
    {32'h8000_0000, 2'd0, 32'h0,          32'h8000_0000}, // R2
    {32'h0040_0100, 2'd0, 32'h0,          32'h8040_0100}, // R2
    {32'h0000_0000, 2'd1, 32'h8000_0000,  32'h0040_0100}, // R3
    {32'h0000_0100, 2'd1, 32'h0000_0100,  32'h0040_0100}, // R4
    {32'h0000_00FF, 2'd0, 32'h0,          32'h0040_0100}, // R7
    {32'h0020_0000, 2'd0, 32'h0,          32'h0060_0100}, // R5
    {32'h0000_0000, 2'd1, 32'hFFFF_FFFF,  32'h0020_0000}, // R6
    {32'h3C00_0000, 2'd0, 32'h0,          32'h3C20_0000}, // R2
    {32'h000A_0000, 2'd0, 32'h0,          32'h3C2A_0000}, // R5
    {32'h0000_0000, 2'd1, 32'h3C02_0000,  32'h0028_0000}  // R3
  };

  logic clk = 0, rst = 1;
  logic [31:0] src = '0, wdata = '0;
  logic utx = 0, urx = 0, qrx = 0, en = 0, we = 0;
  logic [1:0] addr = '0;
  logic [31:0] rdata;
  logic irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_irq_ctrl dut (
    .clk(clk), .rst(rst), .src_i(src),
    .utx_wr_stb(utx), .urx_rd_stb(urx), .qrx_rd_stb(qrx),
    .bus_en(en), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    en = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    en = 0; we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] q);
    en = 1; we = 0; addr = a;
    @(negedge clk);
    en = 0;
    q = rdata;
  endtask

  task automatic pulse_src(logic [31:0] s);
    src = s;
    @(negedge clk);
    src = '0;
  endtask

  initial begin
    logic [31:0] q;
    repeat (5) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(2'd0, q); chk("R1 status", q, 32'h0);
    rd(2'd2, q); chk("R1 mask", q, 32'h0);

    for (int i = 0; i < NV; i++) begin
      src = VEC[i][97:66];
      if (VEC[i][65:64] == 2'd1)      wr(2'd1, VEC[i][63:32]);
      else if (VEC[i][65:64] == 2'd2) wr(2'd2, VEC[i][63:32]);
      else                            @(negedge clk);
      src = '0;
      rd(2'd0, q);
      chk($sformatf("vector %0d", i), q, VEC[i][31:0]);
    end

    // R6 strobes: utx clears 21 and 19
    utx = 1; @(negedge clk); utx = 0;
    rd(2'd0, q); chk("R6 utx strobe", q, 32'h0);
    pulse_src(32'h0005_0000);
    rd(2'd0, q); chk("R5 set 18/16", q, 32'h0005_0000);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0, q); chk("R6 clear reg no effect", q, 32'h0005_0000);
    urx = 1; @(negedge clk); urx = 0;
    rd(2'd0, q); chk("R6 urx strobe", q, 32'h0001_0000);
    qrx = 1; @(negedge clk); qrx = 0;
    rd(2'd0, q); chk("R6 qrx strobe", q, 32'h0);

    // R5 held level does not re-set after clear
    src = 32'h0004_0000; @(negedge clk);
    urx = 1; @(negedge clk); urx = 0;
    @(negedge clk);
    rd(2'd0, q); chk("R5 held level", q, 32'h0);
    src = '0; @(negedge clk);
    pulse_src(32'h0004_0000);
    rd(2'd0, q); chk("R5 new edge", q, 32'h0004_0000);
    urx = 1; @(negedge clk); urx = 0;

    // R9 register map
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, q); chk("R9 status write ignored", q, 32'h0);
    rd(2'd1, q); chk("R9 clear reads zero", q, 32'h0);
    rd(2'd3, q); chk("R9 spare reads zero", q, 32'h0);

    // R8 mask and irq
    wr(2'd2, 32'h0000_0100);
    rd(2'd2, q); chk("R8 mask readback", q, 32'h0000_0100);
    pulse_src(32'h8000_0000);
    @(negedge clk); @(negedge clk);
    chk("R8 unmasked quiet", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h8000_0000);
    pulse_src(32'h0000_0100);
    chk("R8 irq latency", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq high", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h0000_0100);
    @(negedge clk);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule